// File: doc/BRIEF.md
# Register Rename Table with Renamed Flags

This block is the rename stage of a small out-of-order core. Each cycle it may accept one decoded operation that carries two source register indices and an optional destination index. Each source comes back at once in one of two forms. It is either a ready value or a pending producer tag. A ready value comes from the committed register file or from a completed result. A pending tag names the in-flight producer to wait for. An accepted operation that writes a register takes a fresh tag from a 16-entry pool. That tag becomes the newest version of the register.

The condition flags live at register index 8 and are renamed like the eight general registers. A compare that writes index 8 gets a tag, and a later branch that reads index 8 waits on that tag. A result broadcast port marks a tag complete and captures its value. Consumers then read that value directly, without waiting for commit. A commit port moves a completed result into the register file and returns its tag to the pool. A flush input, used on a branch mispredict, drops every speculative mapping in one cycle, so that all sources read the register file again.

Top module: `rename_table`

## Requirements
- R1: `inReady` is low while `flush` is high, and low when `inDstValid` is high and all 16 tags are in use. It is high otherwise.
- R2: An accepted operation with `inDstValid` high receives on `dstTag` the lowest-numbered free tag. That tag stays out of the pool until it is committed or a flush occurs.
- R3: A source whose register has no in-flight writer returns pending=0 and the register-file value. All register-file entries are zero after reset.
- R4: A source whose newest in-flight writer has not completed returns pending=1, and the tag field holds that writer's tag.
- R5: A source whose newest writer's tag has completed returns pending=0 with the broadcast value. This also holds when the broadcast of that tag happens in the same cycle as the lookup.
- R6: Register index 8 is the flags register. It is renamed, looked up and committed exactly like indices 0 to 7.
- R7: Sources are looked up before the operation's own destination mapping is installed. A source equal to the destination therefore sees the previous producer.
- R8: A commit writes `cmtData` into register `cmtReg` and frees `cmtTag`, which can be allocated from the next cycle. The register's mapping is cleared if it still points at `cmtTag` and no new write to that register is accepted in the same cycle.
- R9: In the cycle after `flush`, every source resolves to the register file and all 16 tags are free. A commit in the flush cycle still updates the register file.
- R10: After reset, no register is mapped, all tags are free and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operation offered for rename |
| inReady | output | 1 | Operation accepted this cycle when inValid is also high |
| inSrcA | input | 4 | First source register index (8 = flags) |
| inSrcB | input | 4 | Second source register index (8 = flags) |
| inDstValid | input | 1 | Operation writes a register |
| inDst | input | 4 | Destination register index (8 = flags) |
| dstTag | output | 4 | Tag assigned to the destination |
| srcAPend | output | 1 | First source waits on a producer tag |
| srcATag | output | 4 | Producer tag of first source when pending |
| srcAData | output | 16 | Value of first source when not pending |
| srcBPend | output | 1 | Second source waits on a producer tag |
| srcBTag | output | 4 | Producer tag of second source when pending |
| srcBData | output | 16 | Value of second source when not pending |
| bcValid | input | 1 | Result broadcast valid |
| bcTag | input | 4 | Tag of the broadcast result |
| bcData | input | 16 | Broadcast result value |
| cmtValid | input | 1 | Commit of the oldest completed operation |
| cmtReg | input | 4 | Register written by the committing operation |
| cmtTag | input | 4 | Tag released by the commit |
| cmtData | input | 16 | Value written to the register file |
| flush | input | 1 | Discard all speculative mappings |

## Verification
The hardest situations to reach are those where events coincide. One is a broadcast of a tag in the same cycle that a source reads it. Another is a commit of a register while a newer writer is renamed, or a commit in the same cycle as a flush. A third is the stall when all sixteen tags are held. Directed sequences fill the pool with no commits and line up a lookup against its broadcast. Long random phases then mix renames, broadcasts of in-flight tags, in-order commits of completed tags and rare flushes. A behavioural model built from maps and a queue predicts each output every cycle.

// File: rtl/rename_pkg.sv
package rename_pkg;
  parameter int NUM_GPR  = 8;
  parameter int NUM_TAGS = 16;
  parameter int DATA_W   = 16;
  localparam int NUM_REGS = NUM_GPR + 1;          // last index holds the flags
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int TAG_W    = $clog2(NUM_TAGS);
  localparam int FLAG_IDX = NUM_GPR;

  typedef struct packed {
    logic             alloc;
    logic [TAG_W-1:0] allocTag;
    logic             cmt;
    logic [TAG_W-1:0] cmtTag;
    logic             flush;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              pend;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } srcLook_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inDstValid,
  input  logic             flush,
  input  logic             cmtValid,
  input  logic [TAG_W-1:0] cmtTag,
  output logic             inReady,
  output logic             poolFull,
  output logic [TAG_W-1:0] dstTag,
  output ctrlStrobe_t      strobe
);
  logic [NUM_TAGS-1:0] freeMask;
  logic [TAG_W-1:0]    pickTag;

  // lowest-numbered free tag wins
  always_comb begin
    pickTag = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--)
      if (freeMask[i]) pickTag = TAG_W'(i);
  end

  assign poolFull = ~|freeMask;
  assign inReady  = !flush && !(inDstValid && poolFull);
  assign dstTag   = pickTag;

  always_comb begin
    strobe.alloc    = inValid && inReady && inDstValid;
    strobe.allocTag = pickTag;
    strobe.cmt      = cmtValid;
    strobe.cmtTag   = cmtTag;
    strobe.flush    = flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeMask <= '1;
    end else if (flush) begin
      freeMask <= '1;
    end else begin
      if (cmtValid)     freeMask[cmtTag]  <= 1'b1;
      if (strobe.alloc) freeMask[pickTag] <= 1'b0;
    end
  end
endmodule

// File: rtl/rename_dp.sv
module rename_dp
  import rename_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [REG_W-1:0]  inDst,
  input  logic [REG_W-1:0]  inSrcA,
  input  logic [REG_W-1:0]  inSrcB,
  input  logic [REG_W-1:0]  cmtReg,
  input  logic [DATA_W-1:0] cmtData,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcData,
  output srcLook_t          lookA,
  output srcLook_t          lookB
);
  logic [NUM_REGS-1:0]             mapValid;
  logic [NUM_REGS-1:0][TAG_W-1:0]  mapTag;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [NUM_TAGS-1:0]             tagDone;
  logic [NUM_TAGS-1:0][DATA_W-1:0] tagVal;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mapValid[r] <= 1'b0;
        mapTag[r]   <= '0;
        regFile[r]  <= '0;
      end else begin
        if (strobe.cmt && cmtReg == REG_W'(r)) regFile[r] <= cmtData;
        if (strobe.flush) begin
          mapValid[r] <= 1'b0;
        end else if (strobe.alloc && inDst == REG_W'(r)) begin
          mapValid[r] <= 1'b1;
          mapTag[r]   <= strobe.allocTag;
        end else if (strobe.cmt && mapValid[r] && mapTag[r] == strobe.cmtTag) begin
          mapValid[r] <= 1'b0;
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tagDone[t] <= 1'b0;
        tagVal[t]  <= '0;
      end else if (strobe.alloc && strobe.allocTag == TAG_W'(t)) begin
        tagDone[t] <= 1'b0;
      end else if (bcValid && bcTag == TAG_W'(t)) begin
        tagDone[t] <= 1'b1;
        tagVal[t]  <= bcData;
      end
    end
  end

  function automatic srcLook_t lookUp(input logic [REG_W-1:0] idx);
    srcLook_t         res;
    logic [TAG_W-1:0] t;
    t        = mapTag[idx];
    res.tag  = t;
    res.pend = 1'b0;
    res.data = '0;
    if (!mapValid[idx])             res.data = regFile[idx];
    else if (tagDone[t])            res.data = tagVal[t];
    else if (bcValid && bcTag == t) res.data = bcData;
    else                            res.pend = 1'b1;
    return res;
  endfunction

  always_comb begin
    lookA = lookUp(inSrcA);
    lookB = lookUp(inSrcB);
  end
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rename_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [REG_W-1:0]  inSrcA,
  input  logic [REG_W-1:0]  inSrcB,
  input  logic              inDstValid,
  input  logic [REG_W-1:0]  inDst,
  output logic [TAG_W-1:0]  dstTag,
  output logic              srcAPend,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBPend,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBData,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcData,
  input  logic              cmtValid,
  input  logic [REG_W-1:0]  cmtReg,
  input  logic [TAG_W-1:0]  cmtTag,
  input  logic [DATA_W-1:0] cmtData,
  input  logic              flush
);
  ctrlStrobe_t strobe;
  srcLook_t    lookA, lookB;
  logic        poolFull;

  rename_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDstValid(inDstValid),
    .flush(flush), .cmtValid(cmtValid), .cmtTag(cmtTag),
    .inReady(inReady), .poolFull(poolFull), .dstTag(dstTag), .strobe(strobe)
  );

  rename_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .cmtReg(cmtReg), .cmtData(cmtData),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .lookA(lookA), .lookB(lookB)
  );

  assign srcAPend = lookA.pend;
  assign srcATag  = lookA.tag;
  assign srcAData = lookA.data;
  assign srcBPend = lookB.pend;
  assign srcBTag  = lookB.tag;
  assign srcBData = lookB.data;
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk
  import rename_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             inValid,
  input logic             inReady,
  input logic             inDstValid,
  input logic [TAG_W-1:0] dstTag,
  input logic             srcAPend,
  input logic             srcBPend,
  input logic             poolFull
);
  assert_stall_on_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !inReady);

  assert_stall_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (poolFull && inDstValid) |-> !inReady);

  assert_fresh_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && inDstValid) |=>
      (!(inValid && inReady && inDstValid) || dstTag != $past(dstTag)));

  assert_flush_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!poolFull && !srcAPend && !srcBPend));
endmodule

bind rename_table rename_table_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid), .inReady(inReady),
  .inDstValid(inDstValid), .dstTag(dstTag), .srcAPend(srcAPend),
  .srcBPend(srcBPend), .poolFull(poolFull)
);

// File: tb/rename_table_tb.sv
module rename_table_tb;
  import rename_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              inValid = 0, inDstValid = 0, bcValid = 0, cmtValid = 0, flush = 0;
  logic [REG_W-1:0]  inSrcA = '0, inSrcB = '0, inDst = '0, cmtReg = '0;
  logic [TAG_W-1:0]  bcTag = '0, cmtTag = '0;
  logic [DATA_W-1:0] bcData = '0, cmtData = '0;
  logic              inReady, srcAPend, srcBPend;
  logic [TAG_W-1:0]  dstTag, srcATag, srcBTag;
  logic [DATA_W-1:0] srcAData, srcBData;

  rename_table u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDstValid(inDstValid), .inDst(inDst),
    .dstTag(dstTag), .srcAPend(srcAPend), .srcATag(srcATag), .srcAData(srcAData),
    .srcBPend(srcBPend), .srcBTag(srcBTag), .srcBData(srcBData),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .cmtValid(cmtValid), .cmtReg(cmtReg), .cmtTag(cmtTag), .cmtData(cmtData),
    .flush(flush)
  );

  typedef struct { int r; int t; } flight_t;

  int total = 0, bad = 0;
  bit refMapV[NUM_REGS];
  int refMapT[NUM_REGS];
  int refArf[NUM_REGS];
  bit refArfCommitted[NUM_REGS];
  bit refFree[NUM_TAGS];
  bit refDone[NUM_TAGS];
  int refVal[NUM_TAGS];
  bit afterFlush = 0;
  flight_t inflight[$];

  task automatic chk(input bit ok, input string lbl, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  function automatic int lowestFree();
    for (int i = 0; i < NUM_TAGS; i++) if (refFree[i]) return i;
    return -1;
  endfunction

  function automatic bit expReadyNow();
    return !flush && !(inDstValid && lowestFree() < 0);
  endfunction

  task automatic lookCheck(input int idx, input bit aPend, input int aTag, input int aData,
                           input string side);
    bit ePend; int eTag, eData; string lbl;
    ePend = 0; eTag = refMapT[idx]; eData = 0;
    if (!refMapV[idx]) begin
      eData = refArf[idx];
      lbl = refArfCommitted[idx] ? "R8 committed value in register file" : "R3 register-file source";
    end else if (refDone[eTag]) begin
      eData = refVal[eTag]; lbl = "R5 completed producer";
    end else if (bcValid && int'(bcTag) == eTag) begin
      eData = int'(bcData); lbl = "R5 same-cycle broadcast bypass";
    end else begin
      ePend = 1; lbl = "R4 pending producer";
    end
    if (idx == FLAG_IDX) lbl = {"R6 flags; ", lbl};
    if (inValid && expReadyNow() && inDstValid && int'(inDst) == idx)
      lbl = {"R7 source equals destination; ", lbl};
    if (afterFlush) lbl = {"R9 after flush; ", lbl};
    lbl = {side, " ", lbl};
    chk(aPend == ePend, {lbl, " pend"}, aPend, ePend);
    if (ePend) chk(aTag == eTag, {lbl, " tag"}, aTag, eTag);
    else       chk(aData == eData, {lbl, " data"}, aData, eData);
  endtask

  task automatic checkOutputs();
    bit er; int lf;
    er = expReadyNow();
    lf = lowestFree();
    chk(inReady == er, "R1 inReady", inReady, er);
    if (inValid && er && inDstValid) chk(int'(dstTag) == lf, "R2 lowest free tag", dstTag, lf);
    lookCheck(int'(inSrcA), srcAPend, int'(srcATag), int'(srcAData), "srcA");
    lookCheck(int'(inSrcB), srcBPend, int'(srcBTag), int'(srcBData), "srcB");
  endtask

  task automatic updateModel();
    bit fire; int lf;
    fire = inValid && expReadyNow() && inDstValid;
    lf = lowestFree();
    if (cmtValid) begin
      refArf[cmtReg] = int'(cmtData);
      refArfCommitted[cmtReg] = 1;
      for (int r = 0; r < NUM_REGS; r++)
        if (refMapV[r] && refMapT[r] == int'(cmtTag)) refMapV[r] = 0;
      if (inflight.size() > 0) void'(inflight.pop_front());
    end
    if (bcValid) begin
      refDone[bcTag] = 1;
      refVal[bcTag] = int'(bcData);
    end
    if (fire) begin
      refFree[lf] = 0;
      refDone[lf] = 0;
      refMapV[inDst] = 1;
      refMapT[inDst] = lf;
      inflight.push_back('{r: int'(inDst), t: lf});
    end
    if (cmtValid) refFree[cmtTag] = 1;
    afterFlush = flush;
    if (flush) begin
      for (int r = 0; r < NUM_REGS; r++) refMapV[r] = 0;
      for (int t = 0; t < NUM_TAGS; t++) refFree[t] = 1;
      inflight.delete();
    end
  endtask

  task automatic cycle();
    #2;
    checkOutputs();
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic idle();
    inValid = 0; inDstValid = 0; bcValid = 0; cmtValid = 0; flush = 0;
  endtask

  task automatic randomCycle(input int cmtOdds);
    idle();
    inValid    = ($urandom % 4) != 0;
    inDstValid = ($urandom % 4) != 0;
    inDst  = REG_W'($urandom % NUM_REGS);
    inSrcA = REG_W'($urandom % NUM_REGS);
    inSrcB = REG_W'($urandom % NUM_REGS);
    if (inflight.size() > 0 && ($urandom % 2) == 0) begin
      int k;
      k = int'($urandom % inflight.size());
      if (!refDone[inflight[k].t]) begin
        bcValid = 1;
        bcTag   = TAG_W'(inflight[k].t);
        bcData  = DATA_W'($urandom);
      end
    end
    if (inflight.size() > 0 && refDone[inflight[0].t] && ($urandom % cmtOdds) == 0 &&
        !(bcValid && int'(bcTag) == inflight[0].t)) begin
      cmtValid = 1;
      cmtReg   = REG_W'(inflight[0].r);
      cmtTag   = TAG_W'(inflight[0].t);
      cmtData  = DATA_W'(refVal[inflight[0].t]);
    end
    flush = ($urandom % 64) == 0;
    cycle();
  endtask

  initial begin
    for (int r = 0; r < NUM_REGS; r++) begin refMapV[r] = 0; refMapT[r] = 0; refArf[r] = 0; end
    for (int t = 0; t < NUM_TAGS; t++) begin refFree[t] = 1; refDone[t] = 0; refVal[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R10: reset state
    chk(inReady == 1, "R10 reset inReady", inReady, 1);
    chk(srcAPend == 0 && srcAData == 0, "R10 reset lookup", srcAData, 0);
    @(negedge clk);

    // R6: flags written by a compare, then read by a branch
    idle(); inValid = 1; inDstValid = 1; inDst = REG_W'(FLAG_IDX); inSrcA = 1; inSrcB = 2;
    cycle();
    idle(); inValid = 1; inSrcA = REG_W'(FLAG_IDX); inSrcB = REG_W'(FLAG_IDX);
    cycle();

    // R1/R2: fill the whole pool, then one more write must stall
    for (int i = 0; i < NUM_TAGS; i++) begin
      idle(); inValid = 1; inDstValid = 1; inDst = REG_W'(i % NUM_REGS);
      inSrcA = REG_W'(i % NUM_REGS); inSrcB = 3;
      cycle();
    end
    idle(); inValid = 1; inDstValid = 1; inDst = 4;
    cycle();

    // R9: flush, then R5 bypass of a same-cycle broadcast
    idle(); flush = 1; cycle();
    idle(); inValid = 1; inDstValid = 1; inDst = 2; cycle();
    idle(); inValid = 1; inSrcA = 2; bcValid = 1; bcTag = 0; bcData = 16'hBEEF; cycle();
    // R8: commit, then read the register file
    idle(); cmtValid = 1; cmtReg = 2; cmtTag = 0; cmtData = 16'hBEEF; cycle();
    idle(); inValid = 1; inSrcA = 2; inSrcB = 0; cycle();

    for (int i = 0; i < 3000; i++) randomCycle(8);
    for (int i = 0; i < 3000; i++) randomCycle(2);

    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule